// File: doc/BRIEF.md
# Banked Data Memory Address Mapper

This block turns a data-memory access from a small processor core into a physical location in a 512-byte space made of four banks of 128 bytes. A direct access gives a 7-bit offset taken from the instruction, and the bank comes from two bits of the status register. An access to offset 00h is indirect. It uses an 8-bit pointer register as the low address bits and takes bit 8 of the address from status bit 7.

The mapper decides whether each resolved location is backing RAM, a core register or nothing. An unimplemented location reads as zero and ignores writes. A few core registers answer at the same offset in every bank. The top sixteen bytes of every bank can be folded onto the matching bytes of bank 0, so those bytes are shared. The status register, the pointer and the other mirrored core registers live inside the block, together with the backing RAM, so the whole path can be exercised from the access port.

Reads are combinational in the cycle of the access. Writes take effect at the next rising clock edge.

Top module: `bank_addr_map`

## Requirements
- R1: After reset the status register (offset 03h) and the pointer (offset 04h) read 00h, so bank 0 is selected.
- R2: A direct access (offset 01h..7Fh) resolves to physical address {status[6:5], offset}; bank code 00 is bank 0 and 11 is bank 3.
- R3: An access to offset 00h resolves to {status[7], pointer[7:0]} and is then mapped like a direct access to that bank and in-bank offset.
- R4: When the pointer-resolved in-bank offset is itself 00h, the access reads 00h with rd_zero high, and a write changes no register and no RAM byte.
- R5: Offsets 02h, 03h (status), 04h (pointer), 0Ah and 0Bh reach the same five core registers from every bank, with core_sel high.
- R6: With mirroring enabled (default), offsets 70h..7Fh of every bank resolve to physical address {00, offset}, so all four banks share those bytes.
- R7: RAM begins at offset 20h in banks 0 and 1 and at offset 10h in banks 2 and 3; RAM bytes outside the shared window are distinct per bank.
- R8: Any other offset below the RAM start reads 00h with rd_zero high, and a write there has no effect.
- R9: The address of an access is resolved from the status and pointer values held before its own write; a write to status or to the pointer, direct or through the pointer, steers the next access.
- R10: Exactly one of ram_sel, core_sel and rd_zero is high, and phys_addr is 0 unless ram_sel is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_ofs | input | 7 | In-bank offset from the instruction; 00h means indirect |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the resolved location |
| phys_addr | output | 9 | Resolved RAM address (0 when not RAM) |
| ram_sel | output | 1 | Access hits backing RAM |
| core_sel | output | 1 | Access hits a mirrored core register |
| rd_zero | output | 1 | Access hits nothing; reads as zero |

## Verification
The risky overlap is indirection and a core-register write in the same cycle: a write through the pointer whose target is the pointer or the status register itself. The bench points the pointer at its own offset and at the status offset and writes through offset 00h. It then checks that the write went to the location chosen by the old values. It also checks that the very next access follows the newly written pointer or bank bits, judged by phys_addr and by reading back RAM bytes stored earlier.

// File: rtl/bank_addr_map.sv
module bank_addr_map #(
  parameter int OFS_W         = 7,
  parameter int LOW_RAM_BASE  = 32,
  parameter int HIGH_RAM_BASE = 16,
  parameter int SHARED_LEN    = 16,
  parameter bit MIRROR_EN     = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_en,
  input  logic               acc_wr,
  input  logic [OFS_W-1:0]   acc_ofs,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  output logic [OFS_W+1:0]   phys_addr,
  output logic               ram_sel,
  output logic               core_sel,
  output logic               rd_zero
);
  localparam int ADDR_W = OFS_W + 2;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [OFS_W-1:0] LO_BASE   = OFS_W'(LOW_RAM_BASE);
  localparam logic [OFS_W-1:0] HI_BASE   = OFS_W'(HIGH_RAM_BASE);
  localparam logic [OFS_W-1:0] SH_BASE   = OFS_W'((1 << OFS_W) - SHARED_LEN);
  localparam logic [OFS_W-1:0] O_PCL     = OFS_W'(2);
  localparam logic [OFS_W-1:0] O_STAT    = OFS_W'(3);
  localparam logic [OFS_W-1:0] O_PTR     = OFS_W'(4);
  localparam logic [OFS_W-1:0] O_LATCH   = OFS_W'(10);
  localparam logic [OFS_W-1:0] O_ICTL    = OFS_W'(11);

  logic [7:0] pcl_q, stat_q, ptr_q, latch_q, ictl_q;
  logic [7:0] mem [DEPTH];

  logic              indir;
  logic [ADDR_W-1:0] full;
  logic [1:0]        bank;
  logic [OFS_W-1:0]  eoff;
  logic [OFS_W-1:0]  floor_ofs;
  logic              shared;
  logic [7:0]        core_rd;
  logic              wr_go;

  assign indir     = (acc_ofs == '0);
  assign full      = indir ? ADDR_W'({stat_q[7], ptr_q}) : {stat_q[6:5], acc_ofs};
  assign bank      = full[ADDR_W-1 -: 2];
  assign eoff      = full[OFS_W-1:0];
  assign floor_ofs = bank[1] ? HI_BASE : LO_BASE;
  assign ram_sel   = (eoff >= floor_ofs);
  assign shared    = MIRROR_EN && (eoff >= SH_BASE);
  assign core_sel  = !ram_sel && (eoff == O_PCL || eoff == O_STAT || eoff == O_PTR ||
                                  eoff == O_LATCH || eoff == O_ICTL);
  assign rd_zero   = !ram_sel && !core_sel;
  assign phys_addr = !ram_sel ? '0 : shared ? {2'b00, eoff} : full;
  assign wr_go     = acc_en && acc_wr;

  always_comb begin
    case (eoff)
      O_PCL:   core_rd = pcl_q;
      O_STAT:  core_rd = stat_q;
      O_PTR:   core_rd = ptr_q;
      O_LATCH: core_rd = latch_q;
      O_ICTL:  core_rd = ictl_q;
      default: core_rd = 8'h00;
    endcase
  end

  assign rdata = ram_sel ? mem[phys_addr] : core_sel ? core_rd : 8'h00;

  always_ff @(posedge clk) begin
    if (wr_go && ram_sel) mem[phys_addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcl_q   <= '0;
      stat_q  <= '0;
      ptr_q   <= '0;
      latch_q <= '0;
      ictl_q  <= '0;
    end else if (wr_go && core_sel) begin
      case (eoff)
        O_PCL:   pcl_q   <= wdata;
        O_STAT:  stat_q  <= wdata;
        O_PTR:   ptr_q   <= wdata;
        O_LATCH: latch_q <= wdata;
        O_ICTL:  ictl_q  <= wdata;
        default: ;
      endcase
    end
  end

  // R10: one target class per access
  a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ram_sel, core_sel, rd_zero}) == 1);

  // R8 and R4: zero-reading location returns zero
  a_r8_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_zero |-> rdata == 8'h00);

  // R4 and R8: writes to nothing leave the core registers untouched
  a_r4_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && rd_zero) |=> ($stable(stat_q) && $stable(ptr_q) && $stable(pcl_q) &&
                            $stable(latch_q) && $stable(ictl_q)));

  // R6: shared window always lands in bank 0
  a_r6_shared_bank0: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_sel && MIRROR_EN && acc_ofs >= SH_BASE && !indir) |-> phys_addr[ADDR_W-1 -: 2] == 2'b00);

  // R7: resolved RAM offset is never below the floor of its physical bank
  a_r7_ram_floor: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel |-> phys_addr[OFS_W-1:0] >= (phys_addr[ADDR_W-1] ? HI_BASE : LO_BASE));

  // R9: status only moves on a core write
  a_r9_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_go && core_sel) |=> $stable(stat_q));
endmodule

// File: tb/sim_bank_addr_map.sv
module sim_bank_addr_map;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_en = 1'b0;
  logic       acc_wr = 1'b0;
  logic [6:0] acc_ofs = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [8:0] phys_addr;
  logic       ram_sel, core_sel, rd_zero;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bank_addr_map u0 (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_ofs(acc_ofs),
    .wdata(wdata), .rdata(rdata), .phys_addr(phys_addr), .ram_sel(ram_sel),
    .core_sel(core_sel), .rd_zero(rd_zero)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] ofs, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_ofs = ofs; wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [6:0] ofs, input logic [7:0] exp);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_ofs = ofs;
    #2 chk(req, 16'(rdata), 16'(exp));
    acc_en = 1'b0;
  endtask

  task automatic look(input string req, input logic [6:0] ofs, input logic [8:0] pa,
                      input logic [2:0] cls);
    @(negedge clk);
    acc_ofs = ofs;
    #2 chk(req, 16'(phys_addr), 16'(pa));
    chk(req, 16'({ram_sel, core_sel, rd_zero}), 16'(cls));
  endtask

  task automatic t_reset;
    rd("R1", 7'h03, 8'h00);
    rd("R1", 7'h04, 8'h00);
    look("R1", 7'h25, 9'h025, 3'b100);
  endtask

  task automatic t_direct;
    wr(7'h03, 8'h20);
    look("R2", 7'h30, 9'h0B0, 3'b100);
    wr(7'h30, 8'hAA);
    wr(7'h03, 8'h40);
    look("R2", 7'h15, 9'h115, 3'b100);
    wr(7'h15, 8'h55);
    wr(7'h03, 8'h60);
    look("R2", 7'h15, 9'h195, 3'b100);
    wr(7'h15, 8'h66);
    wr(7'h03, 8'h40);
    rd("R7", 7'h15, 8'h55);
    wr(7'h03, 8'h20);
    rd("R2", 7'h30, 8'hAA);
  endtask

  task automatic t_core;
    wr(7'h03, 8'h60);
    wr(7'h0A, 8'h12);
    wr(7'h0B, 8'h34);
    wr(7'h02, 8'h56);
    look("R5", 7'h0A, 9'h000, 3'b010);
    wr(7'h03, 8'h00);
    rd("R5", 7'h0A, 8'h12);
    rd("R5", 7'h0B, 8'h34);
    rd("R5", 7'h02, 8'h56);
    wr(7'h03, 8'h40);
    wr(7'h04, 8'h9C);
    wr(7'h03, 8'h20);
    rd("R5", 7'h04, 8'h9C);
    rd("R5", 7'h03, 8'h20);
  endtask

  task automatic t_shared;
    wr(7'h03, 8'h00);
    wr(7'h75, 8'h5A);
    for (int b = 1; b < 4; b++) begin
      wr(7'h03, 8'(b << 5));
      look("R6", 7'h75, 9'h075, 3'b100);
      rd("R6", 7'h75, 8'h5A);
    end
    wr(7'h7F, 8'hC3);
    wr(7'h03, 8'h00);
    rd("R6", 7'h7F, 8'hC3);
  endtask

  task automatic t_floor;
    wr(7'h03, 8'h00);
    look("R7", 7'h1F, 9'h000, 3'b001);
    look("R7", 7'h20, 9'h020, 3'b100);
    wr(7'h03, 8'h20);
    look("R7", 7'h10, 9'h000, 3'b001);
    wr(7'h03, 8'h40);
    look("R7", 7'h0F, 9'h000, 3'b001);
    look("R7", 7'h10, 9'h110, 3'b100);
    wr(7'h03, 8'h60);
    look("R7", 7'h10, 9'h190, 3'b100);
  endtask

  task automatic t_unimpl;
    wr(7'h03, 8'h00);
    wr(7'h05, 8'hEE);
    rd("R8", 7'h05, 8'h00);
    look("R8", 7'h05, 9'h000, 3'b001);
    wr(7'h1F, 8'hEE);
    rd("R8", 7'h1F, 8'h00);
    rd("R8", 7'h03, 8'h00);
    rd("R8", 7'h0A, 8'h12);
  endtask

  task automatic t_indirect;
    wr(7'h03, 8'h00);
    wr(7'h04, 8'hA5);
    look("R3", 7'h00, 9'h0A5, 3'b100);
    wr(7'h00, 8'h77);
    wr(7'h03, 8'h20);
    rd("R3", 7'h25, 8'h77);
    wr(7'h03, 8'h80);
    wr(7'h04, 8'h30);
    look("R3", 7'h00, 9'h130, 3'b100);
    wr(7'h00, 8'h99);
    wr(7'h03, 8'h40);
    rd("R3", 7'h30, 8'h99);
    wr(7'h04, 8'h8A);
    rd("R3", 7'h00, 8'h12);
  endtask

  task automatic t_null;
    wr(7'h03, 8'h00);
    wr(7'h04, 8'h80);
    look("R4", 7'h00, 9'h000, 3'b001);
    rd("R4", 7'h00, 8'h00);
    wr(7'h00, 8'hFF);
    rd("R4", 7'h04, 8'h80);
    rd("R4", 7'h03, 8'h00);
    wr(7'h04, 8'h00);
    wr(7'h00, 8'hFF);
    rd("R4", 7'h04, 8'h00);
    rd("R4", 7'h02, 8'h56);
  endtask

  task automatic t_collide;
    wr(7'h03, 8'h00);
    wr(7'h04, 8'h04);
    wr(7'h00, 8'h21);
    rd("R9", 7'h04, 8'h21);
    look("R9", 7'h00, 9'h021, 3'b100);
    wr(7'h04, 8'h83);
    wr(7'h00, 8'h20);
    rd("R9", 7'h03, 8'h20);
    rd("R9", 7'h30, 8'hAA);
    look("R9", 7'h30, 9'h0B0, 3'b100);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    t_reset();
    t_direct();
    t_core();
    t_shared();
    t_floor();
    t_unimpl();
    t_indirect();
    t_null();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule